// File: doc/BRIEF.md
# Multiprocessor Interrupt Poster

This block is a small interrupt unit shared by up to `NUM_CPU` processors over a byte-wide register bus. Each bus access carries the identity of the requesting processor. A read tells a processor its own index or how many processors are in the system. A write names a target processor. The unit then raises an interrupt request line toward that processor.

Delivery is deferred. A write records the target in a staging flag. On the next clock tick the flag moves into a per-processor pending flag, and that flag drives the request line. The request stays asserted, so delivery is retried on every tick, until the target signals acceptance. Repeated writes to a target that is already staged or pending merge into one request. Target numbers that name no processor are dropped.

Read data is registered. It appears one cycle after the read and is zero in every other cycle. Priorities and interrupt vectors are not part of this block.

Top module: `mp_irq_poster`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every request line is low and read data is zero.
- R2: A read with address bit 2 clear returns, in the cycle after the read, the requester index zero-extended to 8 bits.
- R3: A read with address bit 2 set returns, in the cycle after the read, the value `NUM_CPU`.
- R4: Only address bit 2 selects a register. All other address bits have no effect on reads or writes.
- R5: Read data is zero in every cycle that does not directly follow a read, and writes never change it.
- R6: A write with address bit 2 clear and data `t < NUM_CPU` raises request line `t` at the second clock edge after the write. The line is still low at the first edge.
- R7: An asserted request line stays high on every following cycle until its accept input is sampled high. It falls at that edge, unless a new post to the same target was staged one cycle earlier.
- R8: A write with data `>= NUM_CPU` raises no request line.
- R9: Posting to a target that is already staged or pending does not queue a second interrupt. After one accept, that line stays low.
- R10: A write with address bit 2 set changes no request line.
- R11: An accept input that is high while its request line is low has no effect.
- R12: Request lines of different targets are set and cleared independently, including posts in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; only bit 2 decodes |
| busWdata | input | 8 | Write data (target index) |
| busReqId | input | ID_W | Index of the processor making the access |
| busRdata | output | 8 | Registered read data |
| irqReq | output | NUM_CPU | Interrupt request, one line per processor |
| irqAck | input | NUM_CPU | Interrupt accept, one line per processor |

## Verification
Read data is due exactly one edge after the read is sampled. A posted request shows up two edges after the write: one edge to stage it and one to make it pending. A request clears at the edge where its accept is sampled. The bench's reference model advances its own staged and pending flags and its expected read value at each rising edge, using the inputs driven at the previous falling edge. It compares every output at each falling edge. Because of this, every one- and two-cycle latency is checked in the exact cycle it is due, and every other cycle is checked too.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;
  // Address bit that chooses between the identity and the count register
  localparam int SEL_BIT = 2;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic              rdStb;    // read access this cycle
    logic              rdCount;  // read targets the processor-count register
    logic              postStb;  // valid post to an existing processor
    logic [BYTE_W-1:0] postIdx;  // target index of the post
  } ctrl_strobe_t;
endpackage

// File: rtl/mp_irq_lane.sv
module mp_irq_lane (
  input  logic clk,
  input  logic rstN,
  input  logic stageSet,
  input  logic ack,
  output logic pending
);
  logic stageQ;
  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      stageQ <= stageSet;
      pendQ  <= stageQ | (pendQ & ~ack);
    end
  end

  assign pending = pendQ;

  // R6
  staged_becomes_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageQ |=> pendQ);

  // R6
  rise_needs_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(stageQ));

  // R7
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !ack) |=> pendQ);

  // R7
  clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && ack && !stageQ) |=> !pendQ);
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output ctrl_strobe_t      strobes
);
  logic inRange;
  logic countReg;

  assign countReg = busAddr[SEL_BIT];
  assign inRange  = (32'(busWdata) < NUM_CPU);

  always_comb begin
    strobes         = '0;
    strobes.rdStb   = busSel & ~busWrite;
    strobes.rdCount = countReg;
    strobes.postStb = busSel & busWrite & ~countReg & inRange;
    strobes.postIdx = busWdata;
  end

  // R8
  post_in_range_chk: assert final (!strobes.postStb || (32'(strobes.postIdx) < NUM_CPU));
endmodule

// File: rtl/mp_irq_datapath.sv
module mp_irq_datapath
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ID_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic [ID_W-1:0]    reqId,
  input  logic [NUM_CPU-1:0] ackVec,
  output logic [NUM_CPU-1:0] pendVec,
  output logic [NUM_CPU-1:0] stageVec,
  output logic [BYTE_W-1:0]  rdData
);
  localparam logic [BYTE_W-1:0] CountVal = BYTE_W'(NUM_CPU);

  logic [BYTE_W-1:0] rdNext;

  for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_lane
    assign stageVec[gi] = strobes.postStb && (strobes.postIdx == BYTE_W'(gi));
    mp_irq_lane u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .stageSet (stageVec[gi]),
      .ack      (ackVec[gi]),
      .pending  (pendVec[gi])
    );
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdStb) begin
      rdNext = strobes.rdCount ? CountVal : BYTE_W'(reqId);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // R5
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStb |=> (rdData == '0));

  // R9
  single_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stageVec));
endmodule

// File: rtl/mp_irq_poster.sv
module mp_irq_poster
  import mp_irq_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 4,
  parameter int ID_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [7:0]         busWdata,
  input  logic [ID_W-1:0]    busReqId,
  output logic [7:0]         busRdata,
  output logic [NUM_CPU-1:0] irqReq,
  input  logic [NUM_CPU-1:0] irqAck
);
  ctrl_strobe_t       strobes;
  logic [NUM_CPU-1:0] stageVec;

  mp_irq_ctrl #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobes  (strobes)
  );

  mp_irq_datapath #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqId    (busReqId),
    .ackVec   (irqAck),
    .pendVec  (irqReq),
    .stageVec (stageVec),
    .rdData   (busRdata)
  );

  // R3
  count_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr[SEL_BIT]) |=> (busRdata == 8'(NUM_CPU)));

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !busAddr[SEL_BIT]) |=> (busRdata == 8'($past(busReqId))));

  // R8
  bad_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && !busAddr[SEL_BIT] && (32'(busWdata) >= NUM_CPU)) |-> (stageVec == '0));

  // R10
  count_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr[SEL_BIT]) |-> (stageVec == '0));
endmodule

// File: tb/mp_irq_poster_test.sv
module mp_irq_poster_test;
  localparam int N    = 4;
  localparam int AW   = 4;
  localparam int IDW  = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0]    busWdata = '0;
  logic [IDW-1:0] busReqId = '0;
  logic [7:0]    busRdata;
  logic [N-1:0]  irqReq;
  logic [N-1:0]  irqAck = '0;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit running = 1'b1;

  // behavioural reference
  bit mStage[N];
  bit mPend[N];
  int expRd = 0;

  always #10 clk = ~clk;

  mp_irq_poster #(.NUM_CPU(N), .ADDR_W(AW), .ID_W(IDW)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReqId(busReqId),
    .busRdata(busRdata), .irqReq(irqReq), .irqAck(irqAck)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin mStage[i] = 0; mPend[i] = 0; end
      expRd = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        mPend[i]  = mStage[i] || (mPend[i] && !irqAck[i]);
        mStage[i] = busSel && busWrite && !busAddr[2] && (int'(busWdata) == i);
      end
      if (busSel && !busWrite) expRd = busAddr[2] ? N : int'(busReqId);
      else expRd = 0;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      logic [N-1:0] expReq;
      for (int i = 0; i < N; i++) expReq[i] = mPend[i];
      compared++;
      if (irqReq !== expReq) begin
        mismatched++;
        $display("FAIL %s irqReq actual=%b expected=%b at %0t", curReq, irqReq, expReq, $time);
      end
      compared++;
      if (busRdata !== 8'(expRd)) begin
        mismatched++;
        $display("FAIL %s busRdata actual=%0d expected=%0d at %0t", curReq, busRdata, expRd, $time);
      end
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      busSel = 0; busWrite = 0; irqAck = '0;
    end
  endtask

  task automatic rd(logic [AW-1:0] a, logic [IDW-1:0] id);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a; busReqId = id; irqAck = '0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; irqAck = '0;
  endtask

  task automatic ackOnly(logic [N-1:0] v);
    @(negedge clk);
    busSel = 0; busWrite = 0; irqAck = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    idle(2);

    curReq = "R2";
    for (int i = 0; i < N; i++) rd(4'h0, IDW'(i));
    idle(1);

    curReq = "R3";
    rd(4'h4, 2'd1); rd(4'h4, 2'd3);
    idle(1);

    curReq = "R4";
    rd(4'h8, 2'd2); rd(4'hC, 2'd0); rd(4'h1, 2'd3); rd(4'hF, 2'd1);
    wr(4'hA, 8'd3);
    idle(3);
    ackOnly(4'b1000);
    idle(1);

    curReq = "R5";
    wr(4'h0, 8'd0);
    idle(2);
    ackOnly(4'b0001);
    idle(2);

    curReq = "R6";
    wr(4'h0, 8'd2);
    idle(2);

    curReq = "R7";
    idle(5);
    ackOnly(4'b0100);
    idle(2);

    curReq = "R8";
    wr(4'h0, 8'd4); wr(4'h0, 8'd7); wr(4'h0, 8'd255);
    idle(3);

    curReq = "R9";
    wr(4'h0, 8'd1); wr(4'h0, 8'd1);
    idle(2);
    wr(4'h0, 8'd1);
    idle(3);
    ackOnly(4'b0010);
    idle(3);

    curReq = "R10";
    wr(4'h4, 8'd1); wr(4'h4, 8'd0);
    idle(3);

    curReq = "R11";
    ackOnly(4'b1111);
    idle(2);
    rd(4'h0, 2'd2);
    idle(1);

    curReq = "R12";
    wr(4'h0, 8'd0); wr(4'h0, 8'd1); wr(4'h0, 8'd3);
    idle(2);
    ackOnly(4'b0010);
    idle(2);
    ackOnly(4'b1001);
    idle(1);
    wr(4'h0, 8'd2);
    ackOnly(4'b0100);
    idle(1);
    ackOnly(4'b0100);
    idle(3);

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule